// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch is taken. It takes two operands of a configurable width (32 bits by default) and a 3-bit function code. It returns a single bit: 1 means taken, 0 means not taken. The output follows the inputs through logic alone. There is no register between the inputs and the output.

The function code selects one of eight outcomes. Two test the operands for identity or difference. Four order the operands as signed two's-complement numbers. Two ignore the operands and force the result to taken or to not taken. In a processor datapath the block sits beside the arithmetic unit and has its own function select. The instruction decoder drives that select, and the fetch logic uses the result to choose the next fetch address.

Internally, one unit reduces the operands to two flags, "identical" and "signed less-than". A small selector then maps the function code and these two flags onto the result.

Top module: `brc_cond_eval`

## Requirements
- R1: The function code `fn_sel` is 3 bits, encoded as 0=equal, 1=not-equal, 2=less-or-equal, 3=less-than, 4=greater-or-equal, 5=greater-than, 6=always, 7=never.
- R2: With code 0, `taken` is 1 exactly when `op_a` and `op_b` are identical in every bit.
- R3: With code 1, `taken` is the complement of the code-0 result for the same operands.
- R4: With code 3, `taken` is 1 exactly when `op_a` is less than `op_b`, both read as signed two's-complement values.
- R5: With code 2, `taken` is 1 exactly when signed `op_a` is less than or equal to signed `op_b`.
- R6: With code 5, `taken` is 1 exactly when signed `op_a` is greater than signed `op_b`.
- R7: With code 4, `taken` is 1 exactly when signed `op_a` is greater than or equal to signed `op_b`.
- R8: With code 6, `taken` is 1 whatever the operand values are.
- R9: With code 7, `taken` is 0 whatever the operand values are.
- R10: The ordering is signed at the sign boundary. With `op_a`=0x80000000 and `op_b`=0x7FFFFFFF, code 3 gives 1 and code 5 gives 0. With the operands swapped, code 3 gives 0 and code 5 gives 1.
- R11: When the two operands are equal, codes 2 and 4 give 1 and codes 3 and 5 give 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand, the left side of every comparison |
| op_b | input | WIDTH | Second operand, the right side of every comparison |
| fn_sel | input | 3 | Branch function code |
| taken | output | 1 | Branch decision: 1 = taken |

## Verification
The bench targets the sign boundary. An unsigned comparator would rank 0x80000000 above 0x7FFFFFFF and flip the less-than and greater-than results there. A subtractor whose overflow is not handled would fail on operand pairs of opposite sign and large magnitude.

Equal operands are applied under every code. An evaluator that treats the strict and non-strict orderings alike, or that derives greater-than as the plain inverse of less-than, gives a wrong answer on these.

The always and never codes are driven with random operands. A selector that leaks a comparison flag into those codes would let the result follow the data.

Operand pairs that differ in a single bit, including bit 0 and the top bit, catch an equality tree with a dropped or misplaced term.

// File: rtl/brc_pkg.sv
package brc_pkg;

    // Branch function codes (fixed encoding, R1)
    typedef enum logic [2:0] {
        BRC_EQ     = 3'd0,
        BRC_NE     = 3'd1,
        BRC_LE     = 3'd2,
        BRC_LT     = 3'd3,
        BRC_GE     = 3'd4,
        BRC_GT     = 3'd5,
        BRC_ALWAYS = 3'd6,
        BRC_NEVER  = 3'd7
    } brc_fn_e;

    // The two facts every outcome is derived from
    typedef struct packed {
        logic same;   // operands identical
        logic less;   // signed op_a < op_b
    } brc_flags_t;

    // Map a function code and the operand flags onto a decision
    function automatic logic brc_pick(brc_fn_e fn, brc_flags_t f);
        logic r;
        case (fn)
            BRC_EQ:     r = f.same;
            BRC_NE:     r = ~f.same;
            BRC_LE:     r = f.less | f.same;
            BRC_LT:     r = f.less;
            BRC_GE:     r = ~f.less;
            BRC_GT:     r = ~f.less & ~f.same;
            BRC_ALWAYS: r = 1'b1;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/brc_equal.sv
module brc_equal #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             same
);
    logic [WIDTH-1:0] bit_match;

    // Per-bit match, then one AND reduction over all bits
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign bit_match[i] = ~(op_a[i] ^ op_b[i]);
    end

    assign same = &bit_match;
endmodule

// File: rtl/brc_less.sv
module brc_less #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             less
);
    localparam int EXT = WIDTH + 1;

    logic [EXT-1:0] ext_a;
    logic [EXT-1:0] ext_b;
    logic [EXT-1:0] diff;

    // Subtract with one extra sign bit so the result cannot overflow.
    // The top bit of the difference is then the signed less-than.
    assign ext_a = {op_a[WIDTH-1], op_a};
    assign ext_b = {op_b[WIDTH-1], op_b};
    assign diff  = ext_a - ext_b;
    assign less  = diff[EXT-1];
endmodule

// File: rtl/brc_decide.sv
module brc_decide
    import brc_pkg::*;
(
    input  logic [2:0] fn_sel,
    input  brc_flags_t flags,
    output logic       taken
);
    brc_fn_e fn;

    assign fn    = brc_fn_e'(fn_sel);
    assign taken = brc_pick(fn, flags);
endmodule

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
    import brc_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [2:0]       fn_sel,
    output logic             taken
);
    brc_flags_t flags;

    brc_equal #(.WIDTH(WIDTH)) u_equal (
        .op_a (op_a),
        .op_b (op_b),
        .same (flags.same)
    );

    brc_less #(.WIDTH(WIDTH)) u_less (
        .op_a (op_a),
        .op_b (op_b),
        .less (flags.less)
    );

    brc_decide u_decide (
        .fn_sel (fn_sel),
        .flags  (flags),
        .taken  (taken)
    );
endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [2:0]       fn_sel,
    input logic             taken
);
    always_comb begin
        p_always_r8:     assert (fn_sel != 3'd6 || taken)
            else $error("always code not taken");
        p_never_r9:      assert (fn_sel != 3'd7 || !taken)
            else $error("never code taken");
        p_equal_r2:      assert (fn_sel != 3'd0 || taken == (op_a == op_b))
            else $error("equal code mismatch");
        p_notequal_r3:   assert (fn_sel != 3'd1 || taken == (op_a != op_b))
            else $error("not-equal code mismatch");
        p_strict_eq_r11: assert (op_a != op_b || !(fn_sel == 3'd3 || fn_sel == 3'd5) || !taken)
            else $error("strict order taken on equal operands");
        p_loose_eq_r11:  assert (op_a != op_b || !(fn_sel == 3'd2 || fn_sel == 3'd4) || taken)
            else $error("non-strict order not taken on equal operands");
    end
endmodule

bind brc_cond_eval brc_checker #(.WIDTH(WIDTH)) u_brc_checker (
    .op_a   (op_a),
    .op_b   (op_b),
    .fn_sel (fn_sel),
    .taken  (taken)
);

// File: tb/test_brc_cond_eval.sv
`timescale 1ns/1ps
module test_brc_cond_eval;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [2:0]   fn_sel = 3'd0;
    logic         taken;

    int checks = 0;
    int fails  = 0;
    int wd     = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    brc_cond_eval #(.WIDTH(W)) i_brc_cond_eval (
        .op_a   (op_a),
        .op_b   (op_b),
        .fn_sel (fn_sel),
        .taken  (taken)
    );

    // Reference model built from the requirements
    function automatic logic model(logic [W-1:0] a, logic [W-1:0] b, logic [2:0] f);
        logic signed [W-1:0] sa = a;
        logic signed [W-1:0] sb = b;
        case (f)
            3'd0: return a == b;
            3'd1: return a != b;
            3'd2: return sa <= sb;
            3'd3: return sa < sb;
            3'd4: return sa >= sb;
            3'd5: return sa > sb;
            3'd6: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(logic [2:0] f);
        case (f)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R5";
            3'd3: return "R4";
            3'd4: return "R7";
            3'd5: return "R6";
            3'd6: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string req, logic exp);
        checks++;
        if (taken !== exp) begin
            fails++;
            $display("FAIL %s a=%h b=%h fn=%0d actual=%b expected=%b",
                     req, op_a, op_b, fn_sel, taken, exp);
        end
    endtask

    task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic [2:0] f, string req);
        @(negedge clk);
        op_a = a; op_b = b; fn_sel = f;
        @(posedge clk);
        #2;
        check(req, model(a, b, f));
    endtask

    task automatic sweep(logic [W-1:0] a, logic [W-1:0] b, string tag);
        for (int f = 0; f < 8; f++) begin
            apply(a, b, 3'(f), (tag == "") ? req_of(3'(f)) : tag);
        end
    endtask

    always @(posedge clk) begin
        if (!rst && !done) begin
            wd <= wd + 1;
            if (wd > 150000) begin
                fails++;
                checks++;
                $display("FAIL watchdog actual=expired expected=complete");
                $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Initial state: zero operands, code 0 (R1 encoding, R2)
        #2;
        check("R2", 1'b1);

        // R1: every code on one fixed unequal pair
        sweep(32'h0000_0005, 32'h0000_0009, "R1");

        // R11: equal operands under all codes
        sweep(32'h0000_0000, 32'h0000_0000, "R11");
        sweep(32'h8000_0000, 32'h8000_0000, "R11");
        sweep(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R11");
        sweep(32'h7FFF_FFFF, 32'h7FFF_FFFF, "R11");

        // R10: sign boundary in both directions
        apply(32'h8000_0000, 32'h7FFF_FFFF, 3'd3, "R10");
        apply(32'h8000_0000, 32'h7FFF_FFFF, 3'd5, "R10");
        apply(32'h7FFF_FFFF, 32'h8000_0000, 3'd3, "R10");
        apply(32'h7FFF_FFFF, 32'h8000_0000, 3'd5, "R10");
        sweep(32'h8000_0000, 32'h7FFF_FFFF, "R10");
        sweep(32'hFFFF_FFFF, 32'h0000_0000, "");
        sweep(32'h0000_0000, 32'hFFFF_FFFF, "");
        sweep(32'h8000_0000, 32'h0000_0001, "");

        // R2 R3: single-bit differences
        for (int i = 0; i < W; i++) begin
            apply(32'h1234_5678, 32'h1234_5678 ^ (32'h1 << i), 3'd0, "R2");
            apply(32'h1234_5678, 32'h1234_5678 ^ (32'h1 << i), 3'd1, "R3");
        end

        // R8 R9: operand-independent codes
        for (int i = 0; i < 40; i++) begin
            apply($urandom, $urandom, 3'd6, "R8");
            apply($urandom, $urandom, 3'd7, "R9");
        end

        // Random sweep: R4 R5 R6 R7 and the rest
        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] a = $urandom;
            logic [W-1:0] b = ($urandom_range(0, 7) == 0) ? a : $urandom;
            logic [2:0]   f = 3'($urandom_range(0, 7));
            apply(a, b, f, req_of(f));
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule